// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. A prescaler divides the system clock down to an ADC clock, which reaches the outside as a one-cycle `adc_tick` pulse. Each conversion is counted in those ticks. At the first tick of a conversion the block loads the channel and reference selection onto its outputs. It then fires a sample-and-hold strobe and resolves ten trial bits, most significant first, against an external comparator. On the final tick it stores the code and raises a done flag.

Software drives the block through a small register port with four 8-bit addresses. A conversion can start in three ways: software sets a start bit, the trigger input rises (the prescaler is restarted so the sampling point always lands at the same distance from the trigger), or a free-running mode launches each conversion on the ADC clock right after the previous one. The analog comparator and the trial DAC are outside the block.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset all four register addresses read 0, and `dac_code`, `mux_chan`, `mux_ref`, `irq` and all strobes are 0.
- R2: The ADC clock period is 2^s system cycles for a divider field value s of 1..7 (CTRL bits 2:0). A value of 0 gives 2. `adc_tick` pulses once per period while the enable bit is set.
- R3: Ticks are counted from the first tick after the start, with that tick as 1. In a normal conversion `mux_upd` comes on tick 1, `smp_hold` on tick 2 and `conv_done` on tick 13, and these strobes always coincide with a tick.
- R4: The first conversion started after the enable bit goes from 0 to 1 takes 25 ticks: `mux_upd` on 1, `smp_hold` on 14, `conv_done` on 25.
- R5: After sampling, `dac_code` presents one trial bit per tick from bit 9 down to bit 0. A trial bit is kept when `cmp_in` is 1 on the following tick and cleared otherwise. With `cmp_in = (vin >= dac_code)` the result equals vin.
- R6: The result appears as one whole 10-bit value in the cycle after `conv_done`. Address 2 holds bits 7:0 and address 3 holds bits 9:8 in its bits 1:0. The result stays unchanged between done strobes.
- R7: CTRL bit 6 (start) set by a write to CTRL with bits 7 and 6 at 1 begins a conversion. Without free-running, the bit clears at `conv_done`. Writing it while a conversion runs does not restart or lengthen that conversion.
- R8: CTRL bit 4 (done flag) is set at `conv_done` and stays set until a CTRL write with bit 4 at 1. `irq` is high when the flag and CTRL bit 3 are both 1.
- R9: CTRL bit 5 (auto) with MUX bit 5 at 0 selects the trigger. A rising `trig_in` goes through two synchronizer flops and an edge detector, then restarts the prescaler and starts a conversion. `smp_hold` is therefore high right after the (2 + 2·div)-th rising clock edge that follows the input change, whatever the prescaler phase was. Edges that arrive during a conversion are ignored.
- R10: CTRL bit 5 with MUX bit 5 at 1 selects free-running. While start stays 1, consecutive `conv_done` strobes are exactly 13·div cycles apart. Clearing start during a conversion lets that conversion finish and starts no further one.
- R11: `mux_chan` and `mux_ref` take MUX bits 3:0 and 7:6 only at `mux_upd`. A MUX write during a conversion leaves them unchanged.
- R12: A CTRL write with bit 7 at 0 stops a running conversion at once: no `conv_done` follows, start reads 0 and `dac_code` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 MUX, 2 result low, 3 result high |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| trig_in | input | 1 | Asynchronous conversion trigger |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code for the DAC |
| adc_tick | output | 1 | One-cycle pulse per ADC clock period |
| mux_upd | output | 1 | Channel and reference load strobe |
| mux_chan | output | 4 | Active channel |
| mux_ref | output | 2 | Active reference |
| smp_hold | output | 1 | Sample-and-hold strobe |
| conv_done | output | 1 | Conversion complete strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every 10-bit input value through a behavioural comparator. A wrong trial order, or a keep/clear decision read on the wrong tick, shows up as result codes that do not match. It counts ticks to each strobe, both for the long first conversion and for normal ones. It also raises the trigger at all eight prescaler phases. A trigger path that does not restart the prescaler makes the sampling delay depend on the phase, and a missing synchronizer stage shifts that delay by one cycle. Free-running intervals, a repeated start, a trigger edge during a conversion and a MUX write during a conversion are all checked at the ports. Any idle gap, restart or early channel switch changes a counted value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      RA_CTRL   = 2'd0,
      RA_MUX    = 2'd1,
      RA_RES_LO = 2'd2,
      RA_RES_HI = 2'd3
   } ra_e;

   // CTRL bit positions
   localparam int CB_EN   = 7;
   localparam int CB_GO   = 6;
   localparam int CB_AUTO = 5;
   localparam int CB_FLAG = 4;
   localparam int CB_IRQ  = 3;

   // MUX bit positions
   localparam int MB_REF_LSB = 6;
   localparam int MB_SRC     = 5;
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int CNT_W = (1 << SEL_W) - 1;

   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("adc_prescaler: SEL_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic [SEL_W-1:0] shamt;

   always_comb begin
      shamt = (sel == '0) ? SEL_W'(1) : sel;
      lim   = (CNT_W'(1) << shamt) - CNT_W'(1);
      tick  = run && !clr && (cnt_q == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (!run || clr)            cnt_q <= '0;
      else if (cnt_q == lim)           cnt_q <= '0;
      else                             cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic evt
);
   logic last;
   logic prev_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("adc_trig_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= din;
         end
         assign last = s_q;
      end else begin : g_chain
         logic [STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[STAGES-2:0], din};
         end
         assign last = s_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= last;
   end

   assign evt = last & ~prev_q;
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
   parameter int RES_W       = 10,
   parameter int NORM_CYC    = 13,
   parameter int FIRST_EXTRA = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic             launch,
   input  logic             long_mode,
   input  logic             tick,
   input  logic             cmp_in,
   input  logic             chain,
   output logic             busy,
   output logic             upd_stb,
   output logic             smp_stb,
   output logic             done_stb,
   output logic [RES_W-1:0] dac_code,
   output logic [RES_W-1:0] result
);
   localparam int SMP_N    = NORM_CYC - RES_W - 1;
   localparam int LONG_CYC = NORM_CYC + FIRST_EXTRA;
   localparam int STEP_W   = $clog2(LONG_CYC + 1);

   generate
      if (SMP_N < 1) begin : g_bad_cyc
         $error("adc_sar_core: NORM_CYC too short for RES_W");
      end
      if (FIRST_EXTRA < 0) begin : g_bad_extra
         $error("adc_sar_core: FIRST_EXTRA negative");
      end
   endgenerate

   logic              busy_q, long_q, act;
   logic [STEP_W-1:0] step_q, nstep, smp_at, last_at, bit_w;
   logic [RES_W-1:0]  code_q, code_n, res_q;
   logic              in_trial;

   always_comb begin
      nstep    = step_q + STEP_W'(1);
      smp_at   = long_q ? STEP_W'(SMP_N + FIRST_EXTRA) : STEP_W'(SMP_N);
      last_at  = smp_at + STEP_W'(RES_W + 1);
      in_trial = (nstep > smp_at) && (nstep <= smp_at + STEP_W'(RES_W));
      bit_w    = STEP_W'(RES_W - 1) - (nstep - smp_at - STEP_W'(1));
      code_n   = code_q;
      if (nstep == smp_at) begin
         code_n            = '0;
         code_n[RES_W-1]   = 1'b1;
      end else if (in_trial) begin
         for (int b = 0; b < RES_W; b++) begin
            if (b == int'(bit_w))          code_n[b] = cmp_in;
            else if (b + 1 == int'(bit_w)) code_n[b] = 1'b1;
         end
      end
   end

   assign act      = busy_q && tick && !abort;
   assign upd_stb  = act && (nstep == STEP_W'(1));
   assign smp_stb  = act && (nstep == smp_at);
   assign done_stb = act && (nstep == last_at);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         long_q <= 1'b0;
         step_q <= '0;
         code_q <= '0;
         res_q  <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         long_q <= 1'b0;
         step_q <= '0;
         code_q <= '0;
      end else if (!busy_q) begin
         if (launch) begin
            busy_q <= 1'b1;
            long_q <= long_mode;
            step_q <= '0;
            code_q <= '0;
         end
      end else if (tick) begin
         if (nstep == last_at) begin
            res_q  <= code_q;
            step_q <= '0;
            long_q <= 1'b0;
            code_q <= '0;
            busy_q <= chain;
         end else begin
            step_q <= nstep;
            code_q <= code_n;
         end
      end
   end

   assign busy     = busy_q;
   assign dac_code = code_q;
   assign result   = res_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RES_W       = 10,
   parameter int PSC_SEL_W   = 3,
   parameter int CHAN_W      = 4,
   parameter int REF_W       = 2,
   parameter int NORM_CYC    = 13,
   parameter int FIRST_EXTRA = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              trig_in,
   input  logic              cmp_in,
   output logic [RES_W-1:0]  dac_code,
   output logic              adc_tick,
   output logic              mux_upd,
   output logic [CHAN_W-1:0] mux_chan,
   output logic [REF_W-1:0]  mux_ref,
   output logic              smp_hold,
   output logic              conv_done,
   output logic              irq
);
   localparam int HI_W = RES_W - DATA_W;

   generate
      if (DATA_W != 8) begin : g_bad_dw
         $error("adc_seq_ctrl: register map needs DATA_W of 8");
      end
      if (HI_W < 1 || RES_W > 2 * DATA_W) begin : g_bad_res
         $error("adc_seq_ctrl: RES_W must fit two registers");
      end
      if (NORM_CYC != RES_W + 3) begin : g_bad_norm
         $error("adc_seq_ctrl: NORM_CYC must be RES_W + 3");
      end
      if (CHAN_W > 4 || REF_W != 2 || PSC_SEL_W > 3) begin : g_bad_fields
         $error("adc_seq_ctrl: field widths exceed register map");
      end
   endgenerate

   // register state
   logic                 en_q, start_q, auto_q, flag_q, irqen_q, src_q, first_q;
   logic [PSC_SEL_W-1:0] psc_q;
   logic [REF_W-1:0]     ref_q, act_ref_q;
   logic [CHAN_W-1:0]    chan_q, act_chan_q;

   logic wr_ctl, wr_mux, abort, sw_launch, trig_launch, launch, long_mode, chain;
   logic trig_evt, busy, tick, upd, smp, done;
   logic [RES_W-1:0] res_q;

   assign wr_ctl      = reg_wr && (ra_e'(reg_addr) == RA_CTRL);
   assign wr_mux      = reg_wr && (ra_e'(reg_addr) == RA_MUX);
   assign abort       = wr_ctl && !reg_wdata[CB_EN];
   assign sw_launch   = wr_ctl && reg_wdata[CB_EN] && reg_wdata[CB_GO] && !busy;
   assign trig_launch = en_q && auto_q && !src_q && trig_evt && !busy && !wr_ctl;
   assign launch      = sw_launch || trig_launch;
   assign long_mode   = first_q || !en_q;
   assign chain       = auto_q && src_q && start_q;

   adc_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_q),
      .clr   (trig_launch),
      .sel   (psc_q),
      .tick  (tick)
   );

   adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (trig_in),
      .evt   (trig_evt)
   );

   adc_sar_core #(
      .RES_W       (RES_W),
      .NORM_CYC    (NORM_CYC),
      .FIRST_EXTRA (FIRST_EXTRA)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .abort     (abort),
      .launch    (launch),
      .long_mode (long_mode),
      .tick      (tick),
      .cmp_in    (cmp_in),
      .chain     (chain),
      .busy      (busy),
      .upd_stb   (upd),
      .smp_stb   (smp),
      .done_stb  (done),
      .dac_code  (dac_code),
      .result    (res_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         auto_q  <= 1'b0;
         irqen_q <= 1'b0;
         psc_q   <= '0;
      end else if (wr_ctl) begin
         en_q    <= reg_wdata[CB_EN];
         auto_q  <= reg_wdata[CB_AUTO];
         irqen_q <= reg_wdata[CB_IRQ];
         psc_q   <= reg_wdata[PSC_SEL_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  start_q <= 1'b0;
      else if (abort)                              start_q <= 1'b0;
      else if (launch)                             start_q <= 1'b1;
      else if (done && !chain)                     start_q <= 1'b0;
      else if (wr_ctl && busy && auto_q && src_q && !reg_wdata[CB_GO])
                                                   start_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  first_q <= 1'b0;
      else if (launch || abort)                    first_q <= 1'b0;
      else if (wr_ctl && reg_wdata[CB_EN] && !en_q) first_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  flag_q <= 1'b0;
      else if (done)                               flag_q <= 1'b1;
      else if (wr_ctl && reg_wdata[CB_FLAG])       flag_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         src_q  <= 1'b0;
         chan_q <= '0;
      end else if (wr_mux) begin
         ref_q  <= reg_wdata[MB_REF_LSB +: REF_W];
         src_q  <= reg_wdata[MB_SRC];
         chan_q <= reg_wdata[CHAN_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_chan_q <= '0;
         act_ref_q  <= '0;
      end else if (upd) begin
         act_chan_q <= chan_q;
         act_ref_q  <= ref_q;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (ra_e'(reg_addr))
         RA_CTRL: begin
            reg_rdata[CB_EN]           = en_q;
            reg_rdata[CB_GO]           = start_q;
            reg_rdata[CB_AUTO]         = auto_q;
            reg_rdata[CB_FLAG]         = flag_q;
            reg_rdata[CB_IRQ]          = irqen_q;
            reg_rdata[PSC_SEL_W-1:0]   = psc_q;
         end
         RA_MUX: begin
            reg_rdata[MB_REF_LSB +: REF_W] = ref_q;
            reg_rdata[MB_SRC]              = src_q;
            reg_rdata[CHAN_W-1:0]          = chan_q;
         end
         RA_RES_LO: reg_rdata              = res_q[DATA_W-1:0];
         RA_RES_HI: reg_rdata[HI_W-1:0]    = res_q[RES_W-1:DATA_W];
      endcase
   end

   assign adc_tick  = tick;
   assign mux_upd   = upd;
   assign smp_hold  = smp;
   assign conv_done = done;
   assign mux_chan  = act_chan_q;
   assign mux_ref   = act_ref_q;
   assign irq       = flag_q && irqen_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int RES_W  = 10,
   parameter int CHAN_W = 4,
   parameter int REF_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_tick,
   input logic              mux_upd,
   input logic              smp_hold,
   input logic              conv_done,
   input logic [CHAN_W-1:0] mux_chan,
   input logic [REF_W-1:0]  mux_ref,
   input logic              flag_q,
   input logic              start_q,
   input logic              chain,
   input logic [RES_W-1:0]  res_q
);
   // R3: every phase strobe lands on an ADC clock
   p_strobe_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mux_upd || smp_hold || conv_done) |-> adc_tick);

   // R3: phase strobes never overlap
   p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mux_upd, smp_hold, conv_done}));

   // R6: result only moves at completion
   p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(res_q));

   // R7: single conversions drop the start bit at completion
   p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && !chain) |=> !start_q);

   // R8: completion sets the flag
   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> flag_q);

   // R11: active selection moves only on the update strobe
   p_mux_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mux_upd |=> ($stable(mux_chan) && $stable(mux_ref)));
endmodule

bind adc_seq_ctrl adc_seq_chk #(
   .RES_W  (RES_W),
   .CHAN_W (CHAN_W),
   .REF_W  (REF_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .adc_tick  (adc_tick),
   .mux_upd   (mux_upd),
   .smp_hold  (smp_hold),
   .conv_done (conv_done),
   .mux_chan  (mux_chan),
   .mux_ref   (mux_ref),
   .flag_q    (flag_q),
   .start_q   (start_q),
   .chain     (chain),
   .res_q     (res_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       trig_in = 1'b0;
   logic       cmp_in;
   logic [9:0] dac_code;
   logic       adc_tick, mux_upd, smp_hold, conv_done, irq;
   logic [3:0] mux_chan;
   logic [1:0] mux_ref;
   logic [9:0] vin = 10'd0;

   int n_vec = 0, n_err = 0;
   int cyc = 0, tick_total = 0, done_total = 0;
   bit finished = 1'b0;

   assign cmp_in = (vin >= dac_code);

   always #2 clk = ~clk;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .trig_in   (trig_in),
      .cmp_in    (cmp_in),
      .dac_code  (dac_code),
      .adc_tick  (adc_tick),
      .mux_upd   (mux_upd),
      .mux_chan  (mux_chan),
      .mux_ref   (mux_ref),
      .smp_hold  (smp_hold),
      .conv_done (conv_done),
      .irq       (irq)
   );

   always @(posedge clk) begin
      cyc++;
      if (adc_tick)  tick_total++;
      if (conv_done) done_total++;
      if (cyc > 190000 && !finished) begin
         finished = 1'b1;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=<190000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_done();
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         if (conv_done) return;
      end
   endtask

   task automatic read_res(output int r);
      logic [7:0] lo, hi;
      rd(2'd2, lo);
      rd(2'd3, hi);
      r = {hi[1:0], lo};
   endtask

   // start with a CTRL write, report tick index of each strobe
   task automatic run_conv(input logic [7:0] ctl, output int u, output int s, output int dn);
      int t = 0;
      u = -1; s = -1; dn = -1;
      wr(2'd0, ctl);
      for (int k = 0; k < 4000; k++) begin
         if (adc_tick) begin
            t++;
            if (mux_upd)  u = t;
            if (smp_hold) s = t;
            if (conv_done) begin dn = t; break; end
         end
         @(negedge clk);
      end
   endtask

   initial begin
      logic [7:0] d;
      int u, s, dn, r, base, c0, d0, k, per;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), d);
         chk($sformatf("R1 reg%0d", a), d, 0);
      end
      chk("R1 dac_code", dac_code, 0);
      chk("R1 outputs", {irq, mux_chan, mux_ref, adc_tick, mux_upd, smp_hold, conv_done}, 0);

      // R2: divider sweep
      for (int sel = 0; sel < 8; sel++) begin
         wr(2'd0, 8'h00);
         wr(2'd0, 8'h80 | 8'(sel));
         k = 0;
         while (!adc_tick && k < 400) begin @(negedge clk); k++; end
         for (int rep = 0; rep < 2; rep++) begin
            per = 0;
            do begin @(negedge clk); per++; end while (!adc_tick && per < 400);
            chk($sformatf("R2 period sel=%0d", sel), per, (sel == 0) ? 2 : (1 << sel));
         end
      end
      wr(2'd0, 8'h00);

      // R4: first conversion after enable is long
      vin = 10'd700;
      run_conv(8'hC1, u, s, dn);
      chk("R4 upd tick", u, 1);
      chk("R4 sample tick", s, 14);
      chk("R4 done tick", dn, 25);
      read_res(r);
      chk("R5 R6 first result", r, 700);
      rd(2'd0, d);
      chk("R7 R8 ctrl after single", d, 8'h91);

      // R3: normal conversion
      vin = 10'd3;
      run_conv(8'hD1, u, s, dn);
      chk("R3 upd tick", u, 1);
      chk("R3 sample tick", s, 2);
      chk("R3 done tick", dn, 13);

      // R5 R6: every input code
      for (int v = 0; v < 1024; v++) begin
         vin = 10'(v);
         wr(2'd0, 8'hD1);
         wait_done();
         read_res(r);
         chk($sformatf("R5 R6 code %0d", v), r, v);
      end

      // R7: start written again while busy
      vin = 10'd513;
      wr(2'd0, 8'hD1);
      base = tick_total;
      while (tick_total - base < 4) @(negedge clk);
      wr(2'd0, 8'hC1);
      wait_done();
      chk("R7 busy rewrite done tick", tick_total - base + 1, 13);
      d0 = done_total;
      repeat (60) @(negedge clk);
      chk("R7 single done count", done_total - d0, 1);
      read_res(r);
      chk("R7 result", r, 513);

      // R8: flag hold and interrupt
      wr(2'd0, 8'h89);
      chk("R8 irq on", irq, 1);
      rd(2'd0, d);
      chk("R8 flag held", d, 8'h99);
      wr(2'd0, 8'h99);
      chk("R8 irq off", irq, 0);
      rd(2'd0, d);
      chk("R8 flag cleared", d, 8'h89);

      // R11: selection moves only at update strobe
      wr(2'd1, 8'h85);
      wr(2'd0, 8'hD1);
      k = 0;
      while (!mux_upd && k < 400) begin @(negedge clk); k++; end
      @(negedge clk);
      chk("R11 chan loaded", mux_chan, 5);
      chk("R11 ref loaded", mux_ref, 2);
      wr(2'd1, 8'h89);
      wait_done();
      chk("R11 chan held", mux_chan, 5);
      wr(2'd0, 8'hD1);
      k = 0;
      while (!mux_upd && k < 400) begin @(negedge clk); k++; end
      chk("R11 chan before strobe", mux_chan, 5);
      @(negedge clk);
      chk("R11 chan after strobe", mux_chan, 9);
      wait_done();

      // R9: trigger at every prescaler phase, div 8
      wr(2'd1, 8'h00);
      wr(2'd0, 8'hB3);
      for (int ph = 0; ph < 8; ph++) begin
         vin = 10'(100 + 37 * ph);
         repeat (ph) @(negedge clk);
         trig_in = 1'b1;
         k = 0;
         while (!smp_hold && k < 500) begin @(negedge clk); k++; end
         chk($sformatf("R9 trigger to sample ph=%0d", ph), k, 2 + 2 * 8);
         trig_in = 1'b0;
         repeat (4) @(negedge clk);
         trig_in = 1'b1;
         repeat (4) @(negedge clk);
         trig_in = 1'b0;
         wait_done();
         d0 = done_total;
         repeat (300) @(negedge clk);
         chk($sformatf("R9 retrigger ignored ph=%0d", ph), done_total - d0, 1);
         read_res(r);
         chk($sformatf("R9 result ph=%0d", ph), r, 100 + 37 * ph);
      end

      // R10: free-running, div 2
      wr(2'd1, 8'h20);
      vin = 10'd42;
      wr(2'd0, 8'hF1);
      wait_done();
      c0 = cyc;
      for (int i = 0; i < 3; i++) begin
         wait_done();
         chk($sformatf("R10 gapless interval %0d", i), cyc - c0, 26);
         c0 = cyc;
      end
      d0 = done_total;
      wr(2'd0, 8'hA1);
      repeat (200) @(negedge clk);
      chk("R10 stop after current", done_total - d0, 2);
      rd(2'd0, d);
      chk("R10 start cleared", d, 8'hB1);
      read_res(r);
      chk("R10 result", r, 42);

      // R12: disable aborts
      wr(2'd1, 8'h00);
      wr(2'd0, 8'hD1);
      base = tick_total;
      while (tick_total - base < 5) @(negedge clk);
      d0 = done_total;
      wr(2'd0, 8'h11);
      repeat (100) @(negedge clk);
      chk("R12 no done after abort", done_total - d0, 0);
      rd(2'd0, d);
      chk("R12 ctrl after abort", d, 8'h01);
      chk("R12 dac cleared", dac_code, 0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule